// File: doc/BRIEF.md
# AHB-Lite to Request/Acknowledge Bridge with Write Posting and Bounded Wait

This block sits on an AHB-Lite bus as a slave and forwards every real transfer to a simple downstream port that uses a request/acknowledge handshake, as a slow peripheral bus would. Reads cannot complete upstream until the downstream returns data, so the bridge inserts wait states while a read is in flight. Writes are posted instead. A write is placed in a small queue and finished on the bus with no wait state, and the queue empties towards the downstream port at its own pace.

Holding the bus while a downstream agent is busy can close a circular wait: the master waits on the bridge, the bridge waits on the peripheral, and the peripheral waits on the master. The bridge breaks this in two ways. Posting means writes never hold the master. A programmable limit on held cycles abandons any transfer that waits too long and returns an AHB ERROR response. If an acknowledge later arrives for an abandoned read, it is dropped and recorded in a sticky flag.

Upstream and downstream share one clock. Bursts are handled as a series of single transfers. There are no locked transfers and no split or retry responses.

Top module: `ahb_bridge_guard`

## Requirements
- R1: After reset, hreadyout is 1, hresp is 0 (OKAY), dn_req is 0, tmo_event is 0 and late_ack_seen is 0.
- R2: A write is accepted when the address phase has hsel=1, hready=1, htrans NONSEQ (2'b10) or SEQ (2'b11) and hwrite=1. If the write queue has a free slot, its data phase completes with zero wait states and hresp=0.
- R3: Posted writes reach the downstream port in the order they were accepted, with their address and data intact, while the upstream stays idle. Downstream protocol: dn_req rises with dn_write, dn_addr and dn_wdata valid. These hold stable until a cycle in which dn_ack=1. dn_write=1 marks a write.
- R4: A read holds hreadyout low until the downstream acknowledges, then completes one cycle later with hrdata equal to the dn_rdata that arrived with dn_ack. With an empty queue and an acknowledge in the k-th request cycle, the data phase has k+1 wait states.
- R5: A read request is not raised downstream until every earlier posted write has been acknowledged.
- R6: With tmo_limit=N>0 and no acknowledge, a read in flight is abandoned after N request cycles. Its data phase then ends with hresp=1 (ERROR), after N+2 wait states when the queue was empty.
- R7: An ERROR takes two cycles: first hresp=1 with hreadyout=0, then hresp=1 with hreadyout=1.
- R8: An acknowledge in the N-th request cycle, the last one allowed, completes the read with OKAY and N+1 wait states.
- R9: tmo_limit=0 disables the limit, and a held transfer waits for as long as the downstream takes.
- R10: A write that finds the queue full holds hreadyout low until a slot frees and then completes OKAY. The limit also covers this wait. On expiry the write is answered with ERROR and never reaches the downstream.
- R11: An acknowledge for an abandoned read is discarded. It sets late_ack_seen, which stays 1 until reset, and later transfers return correct data.
- R12: tmo_event is high for exactly one cycle for each abandoned transfer.
- R13: An address phase with htrans IDLE (2'b00) or BUSY (2'b01) gets a zero-wait OKAY response and is not forwarded downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hwdata | input | DW | Write data (data phase) |
| hready | input | 1 | Bus-wide ready |
| hreadyout | output | 1 | Ready driven by this slave |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| hrdata | output | DW | Read data |
| dn_req | output | 1 | Downstream request |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | DW | Downstream read data, valid with dn_ack |
| tmo_limit | input | CW | Held-cycle limit, 0 disables it |
| tmo_event | output | 1 | One-cycle pulse per abandoned transfer |
| late_ack_seen | output | 1 | Sticky: an abandoned read was acknowledged |

## Verification
The bench aims at the limit boundary. An acknowledge in the last allowed cycle must still win. An off-by-one counter would return ERROR there, or would let a read one cycle slower complete. It checks that a read issued behind queued writes reaches the downstream only after them, since a design that let the read overtake would log it first. A full queue is pushed both to a late success and to an expiry whose write must vanish, because a leaking queue would still deliver it. A late acknowledge after an abort must set the sticky flag and leave the next read's data untouched. IDLE and BUSY cycles must not raise a downstream request.

// File: rtl/bg_pkg.sv
package bg_pkg;

  // Upstream data-phase tracking
  typedef enum logic [2:0] {
    UP_IDLE,
    UP_WDATA,
    UP_RD_WAIT,
    UP_RD_BUSY,
    UP_RD_DONE,
    UP_ERR1,
    UP_ERR2
  } up_state_e;

  // Downstream port sequencing
  typedef enum logic [1:0] {
    DN_IDLE,
    DN_WR,
    DN_RD,
    DN_ORPHAN
  } dn_state_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;

endpackage

// File: rtl/bg_post_fifo.sv
module bg_post_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);

  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [PW-1:0]       wr_ptr_q, rd_ptr_q, wr_ptr_d, rd_ptr_d;
  logic [CNTW-1:0]     cnt_q, cnt_d;
  logic [DEPTH*AW-1:0] addr_flat;
  logic [DEPTH*DW-1:0] data_flat;
  logic                do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // One register slot per queue entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          slot_en;

    assign slot_en = do_push && (wr_ptr_q == PW'(g));

    always_ff @(posedge clk) begin
      if (slot_en) begin
        addr_q <= push_addr;
        data_q <= push_data;
      end
    end

    assign addr_flat[g*AW +: AW] = addr_q;
    assign data_flat[g*DW +: DW] = data_q;
  end

  assign head_addr = addr_flat[rd_ptr_q*AW +: AW];
  assign head_data = data_flat[rd_ptr_q*DW +: DW];

  always_comb begin
    wr_ptr_d = do_push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/bg_wait_timer.sv
module bg_wait_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          at_limit
);

  logic [CW-1:0] cnt_q, cnt_d;

  // Counts consecutive held cycles; any cycle without run restarts it
  assign cnt_d    = run ? cnt_q + 1'b1 : '0;
  assign at_limit = (limit != '0) && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bg_dn_port.sv
module bg_dn_port import bg_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic [AW-1:0] rd_addr,
  input  logic          abandon,
  input  logic          wq_empty,
  input  logic [AW-1:0] wq_addr,
  input  logic [DW-1:0] wq_data,
  output logic          wq_pop,
  output logic          dn_req,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_ack,
  output logic          idle,
  output logic          rd_done,
  output logic          late_ack
);

  dn_state_e     st_q, st_d;
  logic [AW-1:0] raddr_q;
  logic          raddr_en;

  assign idle     = (st_q == DN_IDLE);
  assign dn_req   = (st_q != DN_IDLE);
  assign dn_write = (st_q == DN_WR);
  assign dn_addr  = (st_q == DN_WR) ? wq_addr : raddr_q;
  assign dn_wdata = (st_q == DN_WR) ? wq_data : '0;
  assign wq_pop   = (st_q == DN_WR) && dn_ack;
  assign rd_done  = (st_q == DN_RD) && dn_ack;
  assign late_ack = (st_q == DN_ORPHAN) && dn_ack;
  assign raddr_en = (st_q == DN_IDLE) && rd_issue;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      DN_IDLE: begin
        if (rd_issue)       st_d = DN_RD;
        else if (!wq_empty) st_d = DN_WR;
      end
      DN_WR: begin
        if (dn_ack) st_d = DN_IDLE;
      end
      DN_RD: begin
        if (dn_ack)       st_d = DN_IDLE;
        else if (abandon) st_d = DN_ORPHAN;
      end
      DN_ORPHAN: begin
        if (dn_ack) st_d = DN_IDLE;
      end
      default: st_d = DN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DN_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (raddr_en) raddr_q <= rd_addr;
  end

endmodule

// File: rtl/ahb_bridge_guard.sv
module ahb_bridge_guard import bg_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [DW-1:0] hwdata,
  input  logic          hready,
  output logic          hreadyout,
  output logic          hresp,
  output logic [DW-1:0] hrdata,
  output logic          dn_req,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_ack,
  input  logic [DW-1:0] dn_rdata,
  input  logic [CW-1:0] tmo_limit,
  output logic          tmo_event,
  output logic          late_ack_seen
);

  up_state_e     st_q, st_d, start_st;
  logic [AW-1:0] ph_addr_q;
  logic [DW-1:0] rdata_q;
  logic          accept;
  logic          wq_push, wq_pop, wq_empty, wq_full;
  logic [AW-1:0] wq_addr;
  logic [DW-1:0] wq_data;
  logic          rd_issue, abandon, dn_idle, rd_done, late_ack;
  logic          tmr_run, tmr_at_limit;
  logic          late_d;

  // Address phase sampling
  assign accept   = hsel && hready && (htrans == TR_NONSEQ || htrans == TR_SEQ);
  assign start_st = accept ? (hwrite ? UP_WDATA : UP_RD_WAIT) : UP_IDLE;

  always_comb begin
    st_d      = st_q;
    hreadyout = 1'b1;
    hresp     = RESP_OKAY;
    wq_push   = 1'b0;
    rd_issue  = 1'b0;
    tmr_run   = 1'b0;
    unique case (st_q)
      UP_IDLE: begin
        if (hready) st_d = start_st;
      end
      UP_WDATA: begin
        if (wq_full) begin
          hreadyout = 1'b0;
          tmr_run   = 1'b1;
          if (tmr_at_limit) st_d = UP_ERR1;
        end else begin
          wq_push = 1'b1;
          if (hready) st_d = start_st;
        end
      end
      UP_RD_WAIT: begin
        hreadyout = 1'b0;
        if (wq_empty && dn_idle) begin
          rd_issue = 1'b1;
          st_d     = UP_RD_BUSY;
        end else begin
          tmr_run = 1'b1;
          if (tmr_at_limit) st_d = UP_ERR1;
        end
      end
      UP_RD_BUSY: begin
        hreadyout = 1'b0;
        if (rd_done) begin
          st_d = UP_RD_DONE;
        end else begin
          tmr_run = 1'b1;
          if (tmr_at_limit) st_d = UP_ERR1;
        end
      end
      UP_RD_DONE: begin
        if (hready) st_d = start_st;
      end
      UP_ERR1: begin
        hreadyout = 1'b0;
        hresp     = RESP_ERROR;
        st_d      = UP_ERR2;
      end
      UP_ERR2: begin
        hresp = RESP_ERROR;
        if (hready) st_d = start_st;
      end
      default: st_d = UP_IDLE;
    endcase
  end

  assign abandon   = (st_q == UP_RD_BUSY) && !rd_done && tmr_at_limit;
  assign tmo_event = (st_q == UP_ERR1);
  assign hrdata    = rdata_q;
  assign late_d    = late_ack_seen || late_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= UP_IDLE;
      late_ack_seen <= 1'b0;
    end else begin
      st_q          <= st_d;
      late_ack_seen <= late_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) ph_addr_q <= haddr;
  end

  always_ff @(posedge clk) begin
    if (rd_done) rdata_q <= dn_rdata;
  end

  bg_post_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_wq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wq_push),
    .push_addr (ph_addr_q),
    .push_data (hwdata),
    .pop       (wq_pop),
    .head_addr (wq_addr),
    .head_data (wq_data),
    .empty     (wq_empty),
    .full      (wq_full)
  );

  bg_wait_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (tmr_run),
    .limit    (tmo_limit),
    .at_limit (tmr_at_limit)
  );

  bg_dn_port #(.AW(AW), .DW(DW)) u_dn (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (rd_issue),
    .rd_addr  (ph_addr_q),
    .abandon  (abandon),
    .wq_empty (wq_empty),
    .wq_addr  (wq_addr),
    .wq_data  (wq_data),
    .wq_pop   (wq_pop),
    .dn_req   (dn_req),
    .dn_write (dn_write),
    .dn_addr  (dn_addr),
    .dn_wdata (dn_wdata),
    .dn_ack   (dn_ack),
    .idle     (dn_idle),
    .rd_done  (rd_done),
    .late_ack (late_ack)
  );

endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsel,
  input logic          hready,
  input logic [1:0]    htrans,
  input logic          hreadyout,
  input logic          hresp,
  input logic          dn_req,
  input logic          dn_write,
  input logic [AW-1:0] dn_addr,
  input logic          dn_ack,
  input logic          tmo_event,
  input logic          late_ack_seen,
  input logic          wq_empty
);

  // R7: first ERROR cycle is followed by the completing ERROR cycle
  assert_err_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  // R7: an ERROR response never begins with ready high
  assert_err_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hresp) |-> !hreadyout);

  // R12: abort pulse lasts one cycle
  assert_tmo_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_event |=> !tmo_event);

  // R11: late-acknowledge flag is sticky
  assert_late_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    late_ack_seen |=> late_ack_seen);

  // R3: request fields hold until acknowledged
  assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_write)));

  // R5: a read request starts only with the write queue empty
  assert_read_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dn_req) && !dn_write) |-> wq_empty);

  // R13: IDLE/BUSY address phases get a zero-wait OKAY
  assert_idle_okay_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready && !htrans[1]) |=> (hreadyout && !hresp));

endmodule

bind ahb_bridge_guard bg_checker #(.AW(AW)) u_bg_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .hsel          (hsel),
  .hready        (hready),
  .htrans        (htrans),
  .hreadyout     (hreadyout),
  .hresp         (hresp),
  .dn_req        (dn_req),
  .dn_write      (dn_write),
  .dn_addr       (dn_addr),
  .dn_ack        (dn_ack),
  .tmo_event     (tmo_event),
  .late_ack_seen (late_ack_seen),
  .wq_empty      (wq_empty)
);

// File: tb/ahb_bridge_guard_bench.sv
module ahb_bridge_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int CW = 16;
  localparam int WD_LIMIT = 20000;
  localparam int LOG_N = 64;

  logic          clk, rst_n;
  logic          hsel, hwrite, hready, hreadyout, hresp;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic [DW-1:0] hwdata, hrdata;
  logic          dn_req, dn_write, dn_ack;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata, dn_rdata;
  logic [CW-1:0] tmo_limit;
  logic          tmo_event, late_ack_seen;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int dn_lat = 1;
  int req_cnt = 0;
  int tmo_cnt = 0;
  int log_n = 0;
  logic [AW-1:0] log_addr [LOG_N];
  logic [DW-1:0] log_data [LOG_N];
  logic          log_wr   [LOG_N];

  assign hready = hreadyout;

  ahb_bridge_guard #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u_ahb_bridge_guard (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hwdata(hwdata), .hready(hready), .hreadyout(hreadyout),
    .hresp(hresp), .hrdata(hrdata), .dn_req(dn_req), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata),
    .tmo_limit(tmo_limit), .tmo_event(tmo_event), .late_ack_seen(late_ack_seen)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] rdat(input logic [AW-1:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  // Downstream agent: acknowledges in the dn_lat-th request cycle (0 = never)
  always @(negedge clk) begin
    if (!rst_n) begin
      dn_ack = 1'b0; req_cnt = 0;
    end else if (dn_ack) begin
      dn_ack = 1'b0; req_cnt = 0;
    end else if (dn_req) begin
      req_cnt++;
      if (dn_lat != 0 && req_cnt == dn_lat) begin
        dn_ack   = 1'b1;
        dn_rdata = rdat(dn_addr);
        if (log_n < LOG_N) begin
          log_addr[log_n] = dn_addr;
          log_data[log_n] = dn_wdata;
          log_wr[log_n]   = dn_write;
        end
        log_n++;
      end
    end else begin
      req_cnt = 0;
    end
  end

  always @(negedge clk) if (rst_n && tmo_event) tmo_cnt++;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      output logic [DW-1:0] rd, output bit err, output int waits, output bit shape_ok);
    bit last_err;
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; hwrite = wr; haddr = a;
    @(posedge clk);
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = wd;
    waits = 0; last_err = 1'b0;
    while (hreadyout !== 1'b1) begin
      last_err = hresp; waits++;
      @(negedge clk);
    end
    rd = hrdata; err = hresp; shape_ok = (err == last_err);
    @(posedge clk);
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 600 && log_n < n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(hreadyout == 1'b1, "R1 hreadyout", hreadyout, 1);
    chk(hresp == 1'b0, "R1 hresp", hresp, 0);
    chk(dn_req == 1'b0, "R1 dn_req", dn_req, 0);
    chk(tmo_event == 1'b0, "R1 tmo_event", tmo_event, 0);
    chk(late_ack_seen == 1'b0, "R1 late flag", late_ack_seen, 0);
  endtask

  task automatic t_post_write();
    logic [DW-1:0] rd; bit err, sh; int w; int n0;
    dn_lat = 5; tmo_limit = '0; n0 = log_n;
    for (int i = 0; i < 4; i++) begin
      xfer(1'b1, 32'h100 + 4*i, 32'hDEAD_0000 + i, rd, err, w, sh);
      chk(w == 0, "R2 write waits", w, 0);
      chk(err == 1'b0, "R2 write resp", err, 0);
    end
    wait_log(n0 + 4);
    chk(log_n == n0 + 4, "R3 write count", log_n, n0 + 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_wr[n0+i] && log_addr[n0+i] == 32'h100 + 4*i, "R3 write addr order",
          log_addr[n0+i], 32'h100 + 4*i);
      chk(log_data[n0+i] == 32'hDEAD_0000 + i, "R3 write data", log_data[n0+i], 32'hDEAD_0000 + i);
    end
  endtask

  task automatic t_read_basic();
    logic [DW-1:0] rd; bit err, sh; int w;
    dn_lat = 3;
    xfer(1'b0, 32'h200, '0, rd, err, w, sh);
    chk(w == 4, "R4 read waits lat3", w, 4);
    chk(err == 1'b0 && rd == rdat(32'h200), "R4 read data", rd, rdat(32'h200));
    dn_lat = 1;
    xfer(1'b0, 32'h240, '0, rd, err, w, sh);
    chk(w == 2, "R4 read waits lat1", w, 2);
    chk(rd == rdat(32'h240), "R4 read data lat1", rd, rdat(32'h240));
  endtask

  task automatic t_order();
    logic [DW-1:0] rd; bit err, sh; int w; int n0;
    dn_lat = 3; n0 = log_n;
    xfer(1'b1, 32'h300, 32'h0000_0A0A, rd, err, w, sh);
    xfer(1'b1, 32'h304, 32'h0000_0B0B, rd, err, w, sh);
    xfer(1'b0, 32'h308, '0, rd, err, w, sh);
    chk(log_wr[n0] && log_addr[n0] == 32'h300, "R5 first write first", log_addr[n0], 32'h300);
    chk(log_wr[n0+1] && log_addr[n0+1] == 32'h304, "R5 second write next", log_addr[n0+1], 32'h304);
    chk(!log_wr[n0+2] && log_addr[n0+2] == 32'h308, "R5 read last", log_addr[n0+2], 32'h308);
    chk(err == 1'b0 && rd == rdat(32'h308), "R5 read data", rd, rdat(32'h308));
  endtask

  task automatic t_timeout();
    logic [DW-1:0] rd; bit err, sh; int w; int n0; int p0;
    tmo_limit = 16'd5;
    dn_lat = 5;
    xfer(1'b0, 32'h400, '0, rd, err, w, sh);
    chk(w == 6 && err == 1'b0, "R8 ack on last allowed cycle", w, 6);
    chk(rd == rdat(32'h400), "R8 data", rd, rdat(32'h400));
    dn_lat = 12; n0 = log_n; p0 = tmo_cnt;
    xfer(1'b0, 32'h404, '0, rd, err, w, sh);
    chk(err == 1'b1, "R6 error resp", err, 1);
    chk(w == 7, "R6 error waits", w, 7);
    chk(sh == 1'b1, "R7 two-cycle error", sh, 1);
    chk(tmo_cnt == p0 + 1, "R12 one pulse", tmo_cnt, p0 + 1);
    chk(late_ack_seen == 1'b0, "R11 flag before late ack", late_ack_seen, 0);
    wait_log(n0 + 1);
    chk(late_ack_seen == 1'b1, "R11 late flag set", late_ack_seen, 1);
    dn_lat = 2;
    xfer(1'b0, 32'h408, '0, rd, err, w, sh);
    chk(err == 1'b0 && w == 3, "R11 next read clean", w, 3);
    chk(rd == rdat(32'h408), "R11 next read data", rd, rdat(32'h408));
    chk(late_ack_seen == 1'b1, "R11 flag sticky", late_ack_seen, 1);
  endtask

  task automatic t_disable();
    logic [DW-1:0] rd; bit err, sh; int w;
    tmo_limit = '0; dn_lat = 40;
    xfer(1'b0, 32'h500, '0, rd, err, w, sh);
    chk(err == 1'b0 && w == 41, "R9 limit disabled", w, 41);
    chk(rd == rdat(32'h500), "R9 data", rd, rdat(32'h500));
  endtask

  task automatic t_full();
    logic [DW-1:0] rd; bit err, sh; int w; int n0; int p0; bit seen;
    tmo_limit = '0; dn_lat = 20; n0 = log_n;
    for (int i = 0; i < DEPTH; i++) xfer(1'b1, 32'h600 + 4*i, 32'h1000 + i, rd, err, w, sh);
    xfer(1'b1, 32'h6F0, 32'h1FFF, rd, err, w, sh);
    chk(w > 0 && err == 1'b0, "R10 full write waits then OKAY", w, 1);
    wait_log(n0 + DEPTH + 1);
    chk(log_addr[n0+DEPTH] == 32'h6F0, "R10 held write delivered", log_addr[n0+DEPTH], 32'h6F0);
    tmo_limit = 16'd3; n0 = log_n; p0 = tmo_cnt;
    for (int i = 0; i < DEPTH; i++) xfer(1'b1, 32'h700 + 4*i, 32'h2000 + i, rd, err, w, sh);
    xfer(1'b1, 32'h7F0, 32'h2FFF, rd, err, w, sh);
    chk(err == 1'b1 && w == 4, "R10 full write times out", w, 4);
    chk(tmo_cnt == p0 + 1, "R12 pulse on write abort", tmo_cnt, p0 + 1);
    wait_log(n0 + DEPTH);
    repeat (40) @(negedge clk);
    chk(log_n == n0 + DEPTH, "R10 aborted write dropped", log_n, n0 + DEPTH);
    seen = 1'b0;
    for (int i = n0; i < log_n && i < LOG_N; i++) if (log_addr[i] == 32'h7F0) seen = 1'b1;
    chk(!seen, "R10 aborted addr absent", seen, 0);
  endtask

  task automatic t_idle_busy();
    int n0;
    n0 = log_n;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      hsel = 1'b1; hwrite = 1'b1; haddr = 32'h800 + 4*i;
      htrans = (i % 2 == 0) ? 2'b01 : 2'b00;
      @(negedge clk);
      chk(hreadyout == 1'b1 && hresp == 1'b0, "R13 zero-wait OKAY", {hreadyout, hresp}, 2'b10);
      chk(dn_req == 1'b0, "R13 not forwarded", dn_req, 0);
    end
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
    repeat (10) @(negedge clk);
    chk(log_n == n0, "R13 no downstream traffic", log_n, n0);
  endtask

  initial begin
    rst_n = 1'b0; hsel = 1'b0; haddr = '0; htrans = 2'b00; hwrite = 1'b0;
    hwdata = '0; tmo_limit = '0; dn_ack = 1'b0; dn_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_post_write();
    t_read_basic();
    t_order();
    t_timeout();
    t_disable();
    t_full();
    t_idle_busy();
    summary();
    $finish;
  end

endmodule